// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block gathers up to 32 interrupt sources and presents two request lines to a processor core. One is a normal request with priority nesting. The other is a fast request that only source 0 drives. Software sets up each source through a small register bus with single-cycle accesses. Each source has a mode word, holding a 3-bit priority and a 2-bit trigger kind, and a 32-bit handler address. Write-one command words enable, disable, set or clear sources.

When the normal request is raised, the handler reads the normal vector word. The read returns the handler address of the winning source and acknowledges it in the same access. The acknowledge pushes the in-service level onto an eight-entry nesting stack, raises the level to the winner's priority, and clears a latched edge. From then on only strictly higher priorities can interrupt. A write to the end-of-interrupt word pops the stack and restores the level and identifier that were in service before. If a vector read finds nothing to serve, it returns a programmable spurious vector and changes no state.

Inputs pass through a two-flop synchroniser. A level-kind source is pending while its synchronised input is at the selected polarity. An edge-kind source latches pending on the selected edge and keeps it until it is acknowledged or cleared.

Top module: `prio_intc`

## Requirements
- R1: After reset, both request outputs are low. The mask, status, core status, spurious, mode and vector words all read zero. With all inputs high, the pending word reads zero.
- R2: The mode word of source i is at byte offset 4*i. Bits 2:0 hold the priority (0 lowest, 7 highest), bits 6:5 hold the kind, and all other bits read zero. The vector word of source i is at 0x80 + 4*i and stores all 32 bits. The spurious vector at 0x134 stores all 32 bits.
- R3: Kind 00 is active-low level and kind 10 is active-high level. For these kinds, pending bit i in the word at 0x10C follows the synchronised input within three clock edges. The set and clear commands have no effect on them.
- R4: Kind 11 latches pending on a rising edge and kind 01 on a falling edge. The opposite edge has no effect. The latched bit stays set after the input returns, until cleared. A write to 0x128 clears pending for each 1 bit, and a write to 0x12C sets pending for each 1 bit.
- R5: A write to 0x120 enables each source whose bit is 1, and a write to 0x124 disables each source whose bit is 1. Zero bits leave the mask unchanged. The mask reads at 0x110.
- R6: The normal request is high exactly when some enabled, pending source other than 0 has a priority above the in-service level, or any priority when nothing is in service. The word at 0x114 shows the fast request in bit 0 and the normal request in bit 1.
- R7: A read of 0x100 while the normal request is high returns the vector of the highest-priority candidate, with the lowest index winning a tie. The read pushes the nesting stack, clears that source's latched edge, and makes the status word at 0x108 return its 5-bit identifier.
- R8: A read of 0x100 while the normal request is low returns the spurious vector and leaves the in-service level and status unchanged.
- R9: A write to 0x130 pops one nesting level and restores the previous identifier and level. Status reads 0 when the stack is empty, and a pop on an empty stack changes nothing. Up to eight levels nest.
- R10: The fast request is high exactly when source 0 is enabled and pending. It ignores the in-service level, and source 0 never raises the normal request. A read of 0x104 returns vector 0 and clears a latched edge on source 0, or returns the spurious vector when the fast request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NSRC | Raw interrupt inputs |
| bus_addr | input | 9 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; vector reads acknowledge at the clock edge ending the cycle |
| bus_rdata | output | 32 | Read data, valid combinationally in the read cycle |
| norm_irq_o | output | 1 | Normal interrupt request |
| fast_irq_o | output | 1 | Fast interrupt request |

## Verification
The checker assumes that a read and a write never share a cycle, so an acknowledge and an end of interrupt cannot collide in the nesting stack. The stimulus issues one bus access per task call, with an idle cycle between accesses. The stack checks also assume that an end-of-interrupt write is only issued against a filled stack when a pop is intended. The bench keeps raw inputs steady for at least three clock edges, so every edge and level passes the synchroniser before the pending word is read.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 9;
  localparam int PRIO_W = 3;
  localparam int ID_W   = 5;

  // bit 0 selects latch-on-edge, bit 1 selects the active-high polarity
  typedef enum logic [1:0] {
    KIND_LVL_LO  = 2'b00,
    KIND_EDG_FAL = 2'b01,
    KIND_LVL_HI  = 2'b10,
    KIND_EDG_RIS = 2'b11
  } src_kind_e;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    src_kind_e         kind;
  } src_mode_t;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
  } nest_ent_t;

  localparam logic [ADDR_W-1:0] OFS_NVEC = 9'h100;
  localparam logic [ADDR_W-1:0] OFS_FVEC = 9'h104;
  localparam logic [ADDR_W-1:0] OFS_STAT = 9'h108;
  localparam logic [ADDR_W-1:0] OFS_PEND = 9'h10C;
  localparam logic [ADDR_W-1:0] OFS_MASK = 9'h110;
  localparam logic [ADDR_W-1:0] OFS_CORE = 9'h114;
  localparam logic [ADDR_W-1:0] OFS_EN   = 9'h120;
  localparam logic [ADDR_W-1:0] OFS_DIS  = 9'h124;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 9'h128;
  localparam logic [ADDR_W-1:0] OFS_SET  = 9'h12C;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 9'h130;
  localparam logic [ADDR_W-1:0] OFS_SPUR = 9'h134;
endpackage

// File: rtl/prio_intc_src.sv
module prio_intc_src
  import prio_intc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      raw_i,
  input  src_kind_e kind_i,
  input  logic      set_i,
  input  logic      clr_i,
  output logic      pend_o
);
  // smp_q[1] is the synchronised input, smp_q[2] its previous value
  logic [2:0] smp_q, smp_d;
  logic       latch_q, latch_d;
  logic       edge_hit;

  always_comb begin
    smp_d = {smp_q[1:0], raw_i};
    unique case (kind_i)
      KIND_EDG_RIS: edge_hit = smp_q[1] & ~smp_q[2];
      KIND_EDG_FAL: edge_hit = ~smp_q[1] & smp_q[2];
      default:      edge_hit = 1'b0;
    endcase
    if (kind_i[0]) latch_d = edge_hit | set_i | (latch_q & ~clr_i);
    else           latch_d = 1'b0;
    if (kind_i[0])      pend_o = latch_q;
    else if (kind_i[1]) pend_o = smp_q[1];
    else                pend_o = ~smp_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      smp_q   <= smp_d;
      latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic [NSRC-1:0]             cand_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  input  logic                        busy_i,
  input  logic [PRIO_W-1:0]           level_i,
  output logic                        req_o,
  output logic [ID_W-1:0]             win_id_o,
  output logic [PRIO_W-1:0]           win_prio_o
);
  logic              found;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;

  // descending scan with >= lets the lower index take a tie
  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_i[i] && (!busy_i || prio_i[i] > level_i) &&
          (!found || prio_i[i] >= best_prio)) begin
        found     = 1'b1;
        best_id   = ID_W'(i);
        best_prio = prio_i[i];
      end
    end
    req_o      = found;
    win_id_o   = best_id;
    win_prio_o = best_prio;
  end
endmodule

// File: rtl/prio_intc_stack.sv
module prio_intc_stack
  import prio_intc_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  nest_ent_t        ent_i,
  output nest_ent_t        top_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] depth_o
);
  nest_ent_t        mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  always_comb begin
    do_push = push_i && (cnt_q != CNT_W'(DEPTH));
    do_pop  = pop_i && !push_i && (cnt_q != '0);
    cnt_d   = cnt_q;
    if (do_push)     cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop) cnt_d = cnt_q - CNT_W'(1);
    top_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (cnt_q == CNT_W'(k + 1)) top_o = mem_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem_q[k] <= '0;
      else if (do_push && cnt_q == CNT_W'(k))    mem_q[k] <= ent_i;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign depth_o = cnt_q;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NEST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              norm_irq_o,
  output logic              fast_irq_o
);
  localparam int CNT_W = $clog2(NEST + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // address decode
  logic            in_mode, in_vec;
  logic [ID_W-1:0] slot;
  logic            cmd_clr, cmd_set, nack, fack, eoi;
  assign in_mode = (bus_addr[ADDR_W-1:ADDR_W-2] == 2'b00);
  assign in_vec  = (bus_addr[ADDR_W-1:ADDR_W-2] == 2'b01);
  assign slot    = bus_addr[ID_W+1:2];
  assign cmd_clr = bus_we && (bus_addr == OFS_CLR);
  assign cmd_set = bus_we && (bus_addr == OFS_SET);
  assign eoi     = bus_we && (bus_addr == OFS_EOI);

  src_mode_t                   mode_all [NSRC];
  logic [DATA_W-1:0]           vec_all  [NSRC];
  logic [NSRC-1:0][PRIO_W-1:0] prio_all;
  logic [NSRC-1:0]             pend_all;
  logic [NSRC-1:0]             en_q, en_d;
  logic [DATA_W-1:0]           spur_q;
  src_mode_t                   mode_wr;
  logic                        arb_req;
  logic [ID_W-1:0]             win_id;
  logic [PRIO_W-1:0]           win_prio;
  nest_ent_t                   stk_top;
  logic                        stk_busy;
  logic [CNT_W-1:0]            stk_depth;

  always_comb begin
    mode_wr.prio = bus_wdata[PRIO_W-1:0];
    mode_wr.kind = src_kind_e'(bus_wdata[6:5]);
  end

  assign nack = bus_re && (bus_addr == OFS_NVEC) && arb_req;
  assign fack = bus_re && (bus_addr == OFS_FVEC) && fast_irq_o;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    src_mode_t         mode_r;
    logic [DATA_W-1:0] vec_r;
    logic              hit, clr_g;
    assign hit   = (int'(slot) == g);
    assign clr_g = (cmd_clr && bus_wdata[g]) || (nack && win_id == ID_W'(g)) ||
                   (g == 0 && fack);

    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) begin
        mode_r <= '0;
        vec_r  <= '0;
      end else begin
        if (bus_we && in_mode && hit) mode_r <= mode_wr;
        if (bus_we && in_vec && hit)  vec_r  <= bus_wdata;
      end
    end

    prio_intc_src u_src (
      .clk   (clk),
      .rst_n (rst_core_n),
      .raw_i (src_i[g]),
      .kind_i(mode_r.kind),
      .set_i (cmd_set && bus_wdata[g]),
      .clr_i (clr_g),
      .pend_o(pend_all[g])
    );

    assign mode_all[g] = mode_r;
    assign vec_all[g]  = vec_r;
    assign prio_all[g] = mode_r.prio;
  end

  // mask commands
  always_comb begin
    en_d = en_q;
    if (bus_we && bus_addr == OFS_EN)       en_d = en_q | bus_wdata[NSRC-1:0];
    else if (bus_we && bus_addr == OFS_DIS) en_d = en_q & ~bus_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      en_q   <= '0;
      spur_q <= '0;
    end else begin
      en_q <= en_d;
      if (bus_we && bus_addr == OFS_SPUR) spur_q <= bus_wdata;
    end
  end

  // source 0 is excluded from normal arbitration
  prio_intc_arb #(.NSRC(NSRC)) u_arb (
    .cand_i    (pend_all & en_q & ~NSRC'(1)),
    .prio_i    (prio_all),
    .busy_i    (stk_busy),
    .level_i   (stk_top.prio),
    .req_o     (arb_req),
    .win_id_o  (win_id),
    .win_prio_o(win_prio)
  );

  prio_intc_stack #(.DEPTH(NEST)) u_stack (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .push_i (nack),
    .pop_i  (eoi),
    .ent_i  ('{prio: win_prio, id: win_id}),
    .top_o  (stk_top),
    .busy_o (stk_busy),
    .depth_o(stk_depth)
  );

  assign norm_irq_o = arb_req;
  assign fast_irq_o = pend_all[0] && en_q[0];

  always_comb begin
    bus_rdata = '0;
    if (in_mode) begin
      if (int'(slot) < NSRC)
        bus_rdata = DATA_W'({mode_all[slot].kind, 2'b00, mode_all[slot].prio});
    end else if (in_vec) begin
      if (int'(slot) < NSRC) bus_rdata = vec_all[slot];
    end else begin
      unique case (bus_addr)
        OFS_NVEC: bus_rdata = arb_req ? vec_all[win_id] : spur_q;
        OFS_FVEC: bus_rdata = fast_irq_o ? vec_all[0] : spur_q;
        OFS_STAT: bus_rdata = stk_busy ? DATA_W'(stk_top.id) : '0;
        OFS_PEND: bus_rdata = DATA_W'(pend_all);
        OFS_MASK: bus_rdata = DATA_W'(en_q);
        OFS_CORE: bus_rdata = DATA_W'({norm_irq_o, fast_irq_o});
        OFS_SPUR: bus_rdata = spur_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_intc_check.sv
module prio_intc_check
  import prio_intc_pkg::*;
#(
  parameter  int NEST  = 8,
  localparam int CNT_W = $clog2(NEST + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic              norm_irq,
  input logic              fast_irq,
  input logic              fast_en,
  input logic              busy,
  input logic [PRIO_W-1:0] cur_prio,
  input logic [CNT_W-1:0]  depth
);
  logic nvec_rd, eoi_wr;
  assign nvec_rd = bus_re && (bus_addr == OFS_NVEC);
  assign eoi_wr  = bus_we && (bus_addr == OFS_EOI);

  assume_single_access: assume property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  assert_depth_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(NEST));

  assert_ack_pushes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nvec_rd && norm_irq) |=> (depth == $past(depth) + CNT_W'(1)));

  assert_ack_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nvec_rd && norm_irq) |=> (busy && (!$past(busy) || cur_prio > $past(cur_prio))));

  assert_spurious_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nvec_rd && !norm_irq) |=> (depth == $past(depth) && $stable(cur_prio)));

  assert_eoi_pops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && depth != '0) |=> (depth == $past(depth) - CNT_W'(1)));

  assert_fast_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |-> !fast_irq);
endmodule

bind prio_intc prio_intc_check #(.NEST(NEST)) u_check (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_addr(bus_addr),
  .bus_we  (bus_we),
  .bus_re  (bus_re),
  .norm_irq(norm_irq_o),
  .fast_irq(fast_irq_o),
  .fast_en (en_q[0]),
  .busy    (stk_busy),
  .cur_prio(stk_top.prio),
  .depth   (stk_depth)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int NSRC = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata;
  logic        norm_irq_o, fast_irq_o;

  int errors = 0;
  int checks = 0;

  localparam logic [31:0] SPUR = 32'hBAD0_0BAD;

  always #4 clk = ~clk;

  prio_intc #(.NSRC(NSRC), .NEST(8)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .norm_irq_o(norm_irq_o), .fast_irq_o(fast_irq_o)
  );

  function automatic logic [2:0] prio_of(int i);
    return 3'((i * 5) % 8);
  endfunction

  function automatic logic [31:0] vec_of(int i);
    return 32'hA000_0000 | (32'(i) << 4);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdchk(string req, string what, logic [8:0] a, logic [31:0] exp);
    logic [31:0] d;
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
    check(req, what, d, exp);
  endtask

  task automatic pins(string req, string what, logic n, logic f);
    #1;
    check(req, {what, " norm"}, 32'(norm_irq_o), 32'(n));
    check(req, {what, " fast"}, 32'(fast_irq_o), 32'(f));
  endtask

  task automatic all_modes(logic [1:0] kind);
    for (int i = 0; i < NSRC; i++) wr(9'(4 * i), {25'b0, kind, 2'b00, prio_of(i)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    logic [31:0] acc;
    int stk_id [8];
    int dep;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5A5_0F0F; pats[3] = 32'h1234_5678;
    src_i = '1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    pins("R1", "reset", 1'b0, 1'b0);
    rdchk("R1", "mask", 9'h110, 32'h0);
    rdchk("R1", "status", 9'h108, 32'h0);
    rdchk("R1", "core", 9'h114, 32'h0);
    rdchk("R1", "spurious", 9'h134, 32'h0);
    rdchk("R1", "pending", 9'h10C, 32'h0);
    rdchk("R1", "mode5", 9'h014, 32'h0);
    rdchk("R1", "vec5", 9'h094, 32'h0);

    // R2 register layout sweep
    for (int i = 0; i < NSRC; i++) begin
      wr(9'(4 * i), 32'hFFFF_FFFF);
      rdchk("R2", "mode all ones", 9'(4 * i), 32'h0000_0067);
      wr(9'(4 * i), {29'b0, prio_of(i)});
      rdchk("R2", "mode prio", 9'(4 * i), {29'b0, prio_of(i)});
      wr(9'(9'h80 + 4 * i), vec_of(i));
      rdchk("R2", "vector", 9'(9'h80 + 4 * i), vec_of(i));
    end
    wr(9'h134, SPUR);
    rdchk("R2", "spurious", 9'h134, SPUR);

    // R5 enable / disable commands
    wr(9'h120, 32'h0000_FFFF);
    rdchk("R5", "enable", 9'h110, 32'h0000_FFFF);
    wr(9'h120, 32'h0);
    rdchk("R5", "enable zero", 9'h110, 32'h0000_FFFF);
    wr(9'h124, 32'h0000_00F0);
    rdchk("R5", "disable", 9'h110, 32'h0000_FF0F);
    wr(9'h124, 32'h0);
    rdchk("R5", "disable zero", 9'h110, 32'h0000_FF0F);
    wr(9'h124, 32'hFFFF_FFFF);
    rdchk("R5", "disable all", 9'h110, 32'h0);

    // R3 level kinds, both polarities, several patterns
    for (int k = 0; k < 2; k++) begin
      all_modes(k == 0 ? 2'b00 : 2'b10);
      for (int p = 0; p < 4; p++) begin
        src_i = pats[p];
        idle(3);
        rdchk("R3", "level pending", 9'h10C, k == 0 ? ~pats[p] : pats[p]);
        wr(9'h12C, 32'hFFFF_FFFF);
        rdchk("R3", "set ignored", 9'h10C, k == 0 ? ~pats[p] : pats[p]);
        wr(9'h128, 32'hFFFF_FFFF);
        rdchk("R3", "clear ignored", 9'h10C, k == 0 ? ~pats[p] : pats[p]);
        pins("R6", "masked", 1'b0, 1'b0);
      end
    end

    // R6 R7 R9 single-source sweep, active-high level kind
    src_i = '0;
    idle(3);
    wr(9'h120, 32'hFFFF_FFFF);
    pins("R6", "idle", 1'b0, 1'b0);
    for (int i = 1; i < NSRC; i++) begin
      src_i = 32'h1 << i;
      idle(3);
      pins("R6", "single", 1'b1, 1'b0);
      rdchk("R7", "single vector", 9'h100, vec_of(i));
      rdchk("R7", "single status", 9'h108, 32'(i));
      pins("R6", "same level blocked", 1'b0, 1'b0);
      wr(9'h130, 32'h0);
      pins("R9", "after pop", 1'b1, 1'b0);
      src_i = '0;
      idle(3);
    end

    // R7 R8 R9 staged nesting through all eight levels
    acc = '0;
    dep = 0;
    for (int p = 0; p < 8; p++) begin
      int win;
      win = -1;
      for (int i = NSRC - 1; i >= 1; i--) begin
        if (prio_of(i) == 3'(p)) begin
          acc[i] = 1'b1;
          win = i;
        end
      end
      src_i = acc;
      idle(3);
      pins("R6", "nest request", 1'b1, 1'b0);
      if (p == 0) rdchk("R6", "core status", 9'h114, 32'h2);
      rdchk("R7", "nest vector", 9'h100, vec_of(win));
      stk_id[dep] = win;
      dep++;
      rdchk("R7", "nest status", 9'h108, 32'(win));
    end
    pins("R6", "top level", 1'b0, 1'b0);
    rdchk("R8", "spurious vector", 9'h100, SPUR);
    rdchk("R8", "status kept", 9'h108, 32'(stk_id[7]));
    for (int p = 7; p >= 0; p--) begin
      wr(9'h130, 32'h0);
      dep--;
      rdchk("R9", "pop status", 9'h108, dep > 0 ? 32'(stk_id[dep - 1]) : 32'h0);
      pins("R9", "pop request", 1'b1, 1'b0);
    end
    src_i = '0;
    idle(3);
    wr(9'h130, 32'h0);
    rdchk("R9", "empty pop", 9'h108, 32'h0);
    pins("R9", "empty pop", 1'b0, 1'b0);

    // R4 rising edge latch
    wr(9'h124, 32'hFFFF_FFFF);
    all_modes(2'b11);
    idle(4);
    wr(9'h128, 32'hFFFF_FFFF);
    rdchk("R4", "rise clear", 9'h10C, 32'h0);
    for (int p = 1; p < 4; p++) begin
      src_i = pats[p];
      idle(3);
      src_i = '0;
      idle(4);
      rdchk("R4", "rise held", 9'h10C, pats[p]);
      wr(9'h128, 32'hFFFF_FFFF);
      rdchk("R4", "rise cleared", 9'h10C, 32'h0);
    end

    // R4 falling edge latch, opposite edge ignored, commands
    all_modes(2'b01);
    src_i = '1;
    idle(4);
    rdchk("R4", "fall ignores rise", 9'h10C, 32'h0);
    src_i = ~pats[2];
    idle(4);
    rdchk("R4", "fall latched", 9'h10C, pats[2]);
    wr(9'h128, 32'h0000_FFFF);
    rdchk("R4", "partial clear", 9'h10C, pats[2] & 32'hFFFF_0000);
    wr(9'h12C, 32'h0000_0006);
    rdchk("R4", "set", 9'h10C, (pats[2] & 32'hFFFF_0000) | 32'h6);

    // R7 acknowledge clears an edge latch
    src_i = '1;
    idle(4);
    wr(9'h128, 32'hFFFF_FFFF);
    wr(9'h120, 32'hFFFF_FFFF);
    wr(9'h12C, 32'h0000_0200);
    pins("R7", "edge request", 1'b1, 1'b0);
    rdchk("R7", "edge vector", 9'h100, vec_of(9));
    rdchk("R7", "edge ack cleared", 9'h10C, 32'h0);
    pins("R7", "edge served", 1'b0, 1'b0);
    wr(9'h130, 32'h0);
    wr(9'h124, 32'hFFFF_FFFF);

    // R10 fast source
    wr(9'h000, 32'h0000_0040);
    src_i = 32'h1;
    idle(4);
    wr(9'h128, 32'hFFFF_FFFF);
    pins("R10", "fast masked", 1'b0, 1'b0);
    rdchk("R10", "fast spurious", 9'h104, SPUR);
    wr(9'h120, 32'h0000_0001);
    pins("R10", "fast only", 1'b0, 1'b1);
    rdchk("R10", "fast core", 9'h114, 32'h1);
    rdchk("R10", "fast vector", 9'h104, vec_of(0));
    pins("R10", "fast level stays", 1'b0, 1'b1);
    src_i = '0;
    idle(3);
    pins("R10", "fast released", 1'b0, 1'b0);
    wr(9'h000, 32'h0000_0060);
    wr(9'h128, 32'h0000_0001);
    src_i = 32'h1;
    idle(4);
    pins("R10", "fast edge", 1'b0, 1'b1);
    rdchk("R10", "fast edge vector", 9'h104, vec_of(0));
    pins("R10", "fast edge acked", 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule